// File: doc/BRIEF.md
# Memory-Mapped Packet FIFO with Length Queues

This block buffers whole packets between a register-mapped host and two word streams. On the transmit side the host stores 32-bit words through a data port and then writes the packet's byte count. That write commits the words pushed since the previous commit as one packet, and a sender state machine streams the packet out with a last flag on its final word. On the receive side, words arriving on the input stream are stored. When the word flagged last is accepted, the byte count presented with it is queued. The host reads that count, which pops it, and then reads the rounded-up number of words.

Each side keeps a separate queue of lengths, so data and lengths stay decoupled. The host sees free space on the transmit side and stored words on the receive side. A side is flushed by writing a key value to its reset register; a third register flushes both sides. Completion and error events collect in a write-1-to-clear status register, and an enable mask turns them into one interrupt line.

The transmit sender has four states. TX_IDLE moves to TX_SEND when the commit queue holds an entry, popping it and loading the word count. TX_SEND presents words and moves to TX_DONE after the handshake of the last word. TX_DONE reports completion and returns to TX_IDLE. A flush request sends any state to TX_FLUSH, which reports the reset as done and returns to TX_IDLE. The receive port has two states: RX_RUN accepts words, and a flush moves it to RX_FLUSH, which reports the reset as done and returns to RX_RUN.

Top module: `pktbuf_mm`

## Requirements
- R1: After reset, transmit vacancy (index 3) reads DEPTH, receive occupancy (index 7) reads 0, status (index 0) reads 0, tx_valid and irq are low and rx_ready is high.
- R2: Words written to index 4 leave on the output stream in order only after a valid length is written to index 5, with tx_last high on the final word and on no other word.
- R3: Transmit vacancy falls by one for each stored word and returns to DEPTH once a packet has fully left.
- R4: A write to index 4 while the transmit store is full drops the word and sets status bit 28.
- R5: A length write whose value is zero, or whose rounded-up word count ceil(bytes/4) differs from the words pushed since the last commit, sets status bit 25 and emits nothing. A byte count that is not a multiple of 4 but rounds up to the pushed word count is accepted.
- R6: Status bit 27 is set after the handshake of the final word of a packet.
- R7: Accepting an input word with rx_last queues rx_bytes and sets status bit 26. Receive occupancy counts the stored words. A read of index 9 returns the byte count in bits 10:0 and pops it. Reads of index 8 then return the packet's words in order.
- R8: A read of index 8 with zero occupancy returns 0 and sets bit 31. A read of index 8 when all words of the popped length have been read returns 0, sets bit 30 and removes nothing. A read of index 9 with no queued length returns 0 and sets bit 29.
- R9: Writing 0xA5 to index 2 flushes the transmit side and then sets bit 24. Writing 0xA5 to index 6 flushes the receive side and then sets bit 23. Writing 0xA5 to index 10 does both. Any other value written to these indices changes nothing.
- R10: Writing index 0 clears exactly the status bits written as 1. irq is high when any status bit is set whose enable bit (index 1, same layout) is set.
- R11: rx_ready is low while the receive store is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hwr | input | 1 | Host write strobe |
| hrd | input | 1 | Host read strobe (pops on the clock edge) |
| haddr | input | 4 | Register index |
| hwdata | input | 32 | Host write data |
| hrdata | output | 32 | Host read data, combinational from haddr |
| irq | output | 1 | Interrupt, enabled status bits ORed |
| tx_valid | output | 1 | Output stream word valid |
| tx_ready | input | 1 | Output stream ready |
| tx_data | output | 32 | Output stream word |
| tx_last | output | 1 | Final word of a packet |
| rx_valid | input | 1 | Input stream word valid |
| rx_ready | output | 1 | Input stream ready |
| rx_data | input | 32 | Input stream word |
| rx_last | input | 1 | Final word of a packet |
| rx_bytes | input | 11 | Packet byte count, sampled with rx_last |

## Verification
The assertions assume a single host access per cycle, never a read and a write together. They also assume that rx_bytes presented with rx_last rounds up to the number of words sent for that packet, and that the host does not push words for a second packet before committing the first. The stimulus keeps to these rules by issuing every host access from one task that spans two cycles. Its input packets carry a byte count derived from the same word count it sends. Every transmit packet is committed, or deliberately left uncommitted and then flushed, before new words are pushed.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
    // register indices on haddr
    localparam logic [3:0] A_STAT    = 4'd0;
    localparam logic [3:0] A_IEN     = 4'd1;
    localparam logic [3:0] A_TXRST   = 4'd2;
    localparam logic [3:0] A_TXVAC   = 4'd3;
    localparam logic [3:0] A_TXDATA  = 4'd4;
    localparam logic [3:0] A_TXLEN   = 4'd5;
    localparam logic [3:0] A_RXRST   = 4'd6;
    localparam logic [3:0] A_RXOCC   = 4'd7;
    localparam logic [3:0] A_RXDATA  = 4'd8;
    localparam logic [3:0] A_RXLEN   = 4'd9;
    localparam logic [3:0] A_LINKRST = 4'd10;

    localparam logic [31:0] RST_KEY   = 32'h0000_00A5;
    localparam logic [31:0] STAT_MASK = 32'hFF80_0000;
    localparam int LEN_W = 11;

    // status bit positions
    localparam int B_RUR = 31;
    localparam int B_ROR = 30;
    localparam int B_RUN = 29;
    localparam int B_TOV = 28;
    localparam int B_TC  = 27;
    localparam int B_RC  = 26;
    localparam int B_TSE = 25;
    localparam int B_TRC = 24;
    localparam int B_RRC = 23;

    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_DONE, TX_FLUSH} tx_state_e;
    typedef enum logic {RX_RUN, RX_FLUSH} rx_state_e;
endpackage

// File: rtl/pb_fifo.sv
module pb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push && !full)  wp_q <= step(wp_q);
            if (pop && !empty)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(push && !full) - CW'(pop && !empty);
        end
    end

    assign dout  = mem[rp_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pb_tx_engine.sv
module pb_tx_engine
    import pktbuf_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cq_empty,
    input  logic [CW-1:0] cq_words,
    input  logic [31:0]   df_head,
    input  logic          tx_ready,
    output logic          cq_pop,
    output logic          df_pop,
    output logic          tx_valid,
    output logic [31:0]   tx_data,
    output logic          tx_last,
    output logic          done_pulse,
    output logic          flush_done
);
    tx_state_e     st_q, st_d;
    logic [CW-1:0] rem_q, rem_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        if (flush) begin
            st_d  = TX_FLUSH;
            rem_d = '0;
        end else begin
            unique case (st_q)
                TX_IDLE: if (!cq_empty) begin
                    st_d  = TX_SEND;
                    rem_d = cq_words;
                end
                TX_SEND: if (tx_ready) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == CW'(1)) st_d = TX_DONE;
                end
                TX_DONE:  st_d = TX_IDLE;
                TX_FLUSH: st_d = TX_IDLE;
                default:  st_d = TX_IDLE;
            endcase
        end
    end

    always_comb begin
        cq_pop     = 1'b0;
        df_pop     = 1'b0;
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        done_pulse = 1'b0;
        flush_done = 1'b0;
        tx_data    = df_head;
        unique case (st_q)
            TX_IDLE:  cq_pop = !cq_empty && !flush;
            TX_SEND: begin
                tx_valid = !flush;
                tx_last  = !flush && (rem_q == CW'(1));
                df_pop   = tx_ready && !flush;
            end
            TX_DONE:  done_pulse = 1'b1;
            TX_FLUSH: flush_done = 1'b1;
            default: ;
        endcase
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || flush)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_DONE) |-> $past(tx_valid && tx_ready && tx_last));
endmodule

// File: rtl/pb_rx_port.sv
module pb_rx_port
    import pktbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic rx_valid,
    input  logic rx_last,
    input  logic df_full,
    input  logic lq_full,
    output logic rx_ready,
    output logic df_push,
    output logic lq_push,
    output logic flush_done
);
    rx_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (flush) st_d = RX_FLUSH;
        else begin
            unique case (st_q)
                RX_RUN:   st_d = RX_RUN;
                RX_FLUSH: st_d = RX_RUN;
                default:  st_d = RX_RUN;
            endcase
        end
    end

    always_comb begin
        rx_ready   = 1'b0;
        flush_done = 1'b0;
        unique case (st_q)
            RX_RUN:   rx_ready = !df_full && !lq_full && !flush;
            RX_FLUSH: flush_done = 1'b1;
            default: ;
        endcase
        df_push = rx_valid && rx_ready;
        lq_push = df_push && rx_last;
    end

    p_backpressure_r11: assert property (@(posedge clk) disable iff (!rst_n)
        df_full |-> !df_push);
endmodule

// File: rtl/pktbuf_mm.sv
module pktbuf_mm
    import pktbuf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int LQ_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hwr,
    input  logic        hrd,
    input  logic [3:0]  haddr,
    input  logic [31:0] hwdata,
    output logic [31:0] hrdata,
    output logic        irq,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [31:0] rx_data,
    input  logic        rx_last,
    input  logic [10:0] rx_bytes
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int LCW = $clog2(LQ_DEPTH + 1);
    localparam int NW  = LEN_W + 1;

    // ---------------- host decode ----------------
    logic key_ok, link_hit, tx_flush, rx_flush;
    logic wr_txdata, wr_txlen, wr_stat, wr_ien, rd_rxdata, rd_rxlen;

    assign key_ok    = (hwdata == RST_KEY);
    assign link_hit  = hwr && haddr == A_LINKRST && key_ok;
    assign tx_flush  = link_hit || (hwr && haddr == A_TXRST && key_ok);
    assign rx_flush  = link_hit || (hwr && haddr == A_RXRST && key_ok);
    assign wr_txdata = hwr && haddr == A_TXDATA;
    assign wr_txlen  = hwr && haddr == A_TXLEN;
    assign wr_stat   = hwr && haddr == A_STAT;
    assign wr_ien    = hwr && haddr == A_IEN;
    assign rd_rxdata = hrd && haddr == A_RXDATA;
    assign rd_rxlen  = hrd && haddr == A_RXLEN;

    // ---------------- transmit side ----------------
    logic          tdf_full, tdf_empty, tdf_push, tdf_pop;
    logic [31:0]   tdf_head;
    logic [CW-1:0] tdf_cnt;
    logic          cq_full, cq_empty, cq_push, cq_pop;
    logic [CW-1:0] cq_head;
    logic [LCW-1:0] cq_cnt;
    logic [CW-1:0] pend_q;
    logic [NW-1:0] tx_need;
    logic          len_ok, tx_done, trc_evt;

    assign tdf_push = wr_txdata && !tdf_full && !tx_flush;
    assign tx_need  = ({1'b0, hwdata[LEN_W-1:0]} + NW'(3)) >> 2;
    assign len_ok   = (hwdata[LEN_W-1:0] != '0) && (tx_need == NW'(pend_q));
    assign cq_push  = wr_txlen && len_ok && !cq_full && !tx_flush;

    always_ff @(posedge clk) begin
        if (!rst_n || tx_flush) pend_q <= '0;
        else if (cq_push)       pend_q <= '0;
        else if (tdf_push)      pend_q <= pend_q + 1'b1;
    end

    pb_fifo #(.W(32), .DEPTH(DEPTH), .CW(CW)) u_tx_data (
        .clk(clk), .rst_n(rst_n), .clr(tx_flush), .push(tdf_push), .din(hwdata),
        .pop(tdf_pop), .dout(tdf_head), .full(tdf_full), .empty(tdf_empty), .count(tdf_cnt));

    pb_fifo #(.W(CW), .DEPTH(LQ_DEPTH), .CW(LCW)) u_tx_commit (
        .clk(clk), .rst_n(rst_n), .clr(tx_flush), .push(cq_push), .din(tx_need[CW-1:0]),
        .pop(cq_pop), .dout(cq_head), .full(cq_full), .empty(cq_empty), .count(cq_cnt));

    pb_tx_engine #(.CW(CW)) u_tx_eng (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cq_empty(cq_empty), .cq_words(cq_head),
        .df_head(tdf_head), .tx_ready(tx_ready), .cq_pop(cq_pop), .df_pop(tdf_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .done_pulse(tx_done), .flush_done(trc_evt));

    // ---------------- receive side ----------------
    logic            rdf_full, rdf_empty, rdf_push, rdf_pop;
    logic [31:0]     rdf_head;
    logic [CW-1:0]   rdf_cnt;
    logic            rlq_full, rlq_empty, rlq_push, rlq_pop;
    logic [LEN_W-1:0] rlq_head;
    logic [LCW-1:0]  rlq_cnt;
    logic [CW-1:0]   rd_rem_q;
    logic [NW-1:0]   rx_need;
    logic            rrc_evt, rdata_ok;

    pb_rx_port u_rx_port (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .rx_valid(rx_valid), .rx_last(rx_last),
        .df_full(rdf_full), .lq_full(rlq_full), .rx_ready(rx_ready), .df_push(rdf_push),
        .lq_push(rlq_push), .flush_done(rrc_evt));

    pb_fifo #(.W(32), .DEPTH(DEPTH), .CW(CW)) u_rx_data (
        .clk(clk), .rst_n(rst_n), .clr(rx_flush), .push(rdf_push), .din(rx_data),
        .pop(rdf_pop), .dout(rdf_head), .full(rdf_full), .empty(rdf_empty), .count(rdf_cnt));

    pb_fifo #(.W(LEN_W), .DEPTH(LQ_DEPTH), .CW(LCW)) u_rx_len (
        .clk(clk), .rst_n(rst_n), .clr(rx_flush), .push(rlq_push), .din(rx_bytes),
        .pop(rlq_pop), .dout(rlq_head), .full(rlq_full), .empty(rlq_empty), .count(rlq_cnt));

    assign rdata_ok = !rdf_empty && (rd_rem_q != '0);
    assign rdf_pop  = rd_rxdata && rdata_ok && !rx_flush;
    assign rlq_pop  = rd_rxlen && !rlq_empty && !rx_flush;
    assign rx_need  = ({1'b0, rlq_head} + NW'(3)) >> 2;

    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) rd_rem_q <= '0;
        else if (rlq_pop)       rd_rem_q <= CW'(rx_need);
        else if (rdf_pop)       rd_rem_q <= rd_rem_q - 1'b1;
    end

    // ---------------- status and interrupt ----------------
    logic [31:0] stat_q, ien_q, set_v, clr_v;

    always_comb begin
        set_v        = '0;
        set_v[B_RUR] = rd_rxdata && rdf_empty;
        set_v[B_ROR] = rd_rxdata && !rdf_empty && (rd_rem_q == '0);
        set_v[B_RUN] = rd_rxlen && rlq_empty;
        set_v[B_TOV] = (wr_txdata && tdf_full) || (wr_txlen && len_ok && cq_full);
        set_v[B_TC]  = tx_done;
        set_v[B_RC]  = rlq_push;
        set_v[B_TSE] = wr_txlen && !len_ok;
        set_v[B_TRC] = trc_evt;
        set_v[B_RRC] = rrc_evt;
        clr_v        = wr_stat ? hwdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_v) | set_v) & STAT_MASK;
            if (wr_ien) ien_q <= hwdata & STAT_MASK;
        end
    end

    assign irq = |(stat_q & ien_q);

    always_comb begin
        unique case (haddr)
            A_STAT:   hrdata = stat_q;
            A_IEN:    hrdata = ien_q;
            A_TXVAC:  hrdata = 32'(DEPTH) - 32'(tdf_cnt);
            A_RXOCC:  hrdata = 32'(rdf_cnt);
            A_RXDATA: hrdata = rdata_ok ? rdf_head : '0;
            A_RXLEN:  hrdata = rlq_empty ? '0 : 32'(rlq_head);
            default:  hrdata = '0;
        endcase
    end

    p_rur_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rxdata && rdf_empty |=> stat_q[B_RUR]);
    p_rrc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> ##1 stat_q[B_RRC]);
    p_tse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txlen && hwdata[LEN_W-1:0] == '0 |=> stat_q[B_TSE] && !tx_valid);
    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cq_push |=> cq_cnt != '0);
    p_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rlq_push |=> rlq_cnt != '0 && stat_q[B_RC]);
endmodule

// File: tb/pktbuf_mm_test.sv
module pktbuf_mm_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LQD   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hwr = 1'b0, hrd = 1'b0;
    logic [3:0]  haddr = '0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        irq, tx_valid, tx_last, rx_ready;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [31:0] rx_data = '0;
    logic [10:0] rx_bytes = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] got_d [16];
    logic        got_l [16];
    int          got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    pktbuf_mm #(.DEPTH(DEPTH), .LQ_DEPTH(LQD)) uut (
        .clk(clk), .rst_n(rst_n), .hwr(hwr), .hrd(hrd), .haddr(haddr), .hwdata(hwdata),
        .hrdata(hrdata), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_bytes(rx_bytes));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); hwr = 1'b1; haddr = a; hwdata = d;
        @(negedge clk); hwr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); hrd = 1'b1; haddr = a;
        #1 v = hrdata;
        @(negedge clk); hrd = 1'b0;
    endtask

    task automatic collect();
        logic seen_last;
        seen_last = 1'b0;
        got_n = 0;
        tx_ready = 1'b1;
        for (int k = 0; k < 100 && !seen_last; k++) begin
            @(negedge clk);
            if (tx_valid) begin
                got_d[got_n] = tx_data;
                got_l[got_n] = tx_last;
                got_n++;
                if (tx_last) seen_last = 1'b1;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_send(input int bytes, input int tag);
        int w;
        w = (bytes + 3) / 4;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 32'(tag * 256 + i);
            rx_last = (i == w - 1); rx_bytes = 11'(bytes);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0;
        end
        rx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(4'd3, v); check("R1 vacancy", v, DEPTH);
        brd(4'd7, v); check("R1 occupancy", v, 0);
        brd(4'd0, v); check("R1 status", v, 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 rx_ready", 32'(rx_ready), 1);

        // transmit sweep over every byte count that fits: R2 R3 R6 R10
        for (int len = 1; len <= 4 * DEPTH; len++) begin
            w = (len + 3) / 4;
            for (int i = 0; i < w; i++) bwr(4'd4, 32'(len * 256 + i));
            brd(4'd3, v); check("R3 vacancy after push", v, 32'(DEPTH - w));
            tx_ready = 1'b1;
            repeat (3) @(negedge clk);
            check("R2 nothing before commit", 32'(tx_valid), 0);
            tx_ready = 1'b0;
            bwr(4'd5, 32'(len));
            collect();
            check("R2 word count", 32'(got_n), 32'(w));
            for (int i = 0; i < got_n && i < 16; i++) begin
                check("R2 word order", got_d[i], 32'(len * 256 + i));
                check("R2 last flag", 32'(got_l[i]), 32'(i == w - 1));
            end
            brd(4'd0, v); check("R6 tx complete", v, 32'h0800_0000);
            brd(4'd3, v); check("R3 vacancy restored", v, DEPTH);
            bwr(4'd0, 32'h0800_0000);
            brd(4'd0, v); check("R10 cleared", v, 0);
        end

        // R5 mismatch, then odd length accepted
        bwr(4'd4, 32'hA0); bwr(4'd4, 32'hA1);
        bwr(4'd5, 32'd12);
        tx_ready = 1'b1; repeat (3) @(negedge clk);
        check("R5 no emit on mismatch", 32'(tx_valid), 0);
        tx_ready = 1'b0;
        brd(4'd0, v); check("R5 size error", v, 32'h0200_0000);
        bwr(4'd0, 32'hFFFF_FFFF);
        bwr(4'd5, 32'd5);
        collect();
        check("R5 odd length count", 32'(got_n), 2);
        check("R5 odd length data", got_d[1], 32'hA1);
        check("R5 odd length last", 32'(got_l[1]), 1);
        bwr(4'd0, 32'hFFFF_FFFF);
        bwr(4'd5, 32'd0);
        brd(4'd0, v); check("R5 zero length", v, 32'h0200_0000);

        // R10 irq and selective clear
        bwr(4'd1, 32'h0200_0000);
        check("R10 irq on", 32'(irq), 1);
        bwr(4'd1, 32'h0100_0000);
        check("R10 irq masked", 32'(irq), 0);
        bwr(4'd1, 32'h0200_0000);

        // R9 ignored and real transmit reset
        bwr(4'd4, 32'h1); bwr(4'd4, 32'h2); bwr(4'd4, 32'h3);
        bwr(4'd2, 32'h5A);
        brd(4'd3, v); check("R9 wrong key ignored", v, DEPTH - 3);
        bwr(4'd2, 32'hA5);
        @(negedge clk);
        brd(4'd3, v); check("R9 tx flushed", v, DEPTH);
        brd(4'd0, v); check("R9 tx reset done", v, 32'h0300_0000);
        bwr(4'd0, 32'h0200_0000);
        brd(4'd0, v); check("R10 only written bits cleared", v, 32'h0100_0000);
        check("R10 irq off", 32'(irq), 0);
        bwr(4'd0, 32'hFFFF_FFFF);

        // R4 overflow
        for (int i = 0; i <= DEPTH; i++) bwr(4'd4, 32'(16 + i));
        brd(4'd3, v); check("R4 vacancy zero", v, 0);
        brd(4'd0, v); check("R4 overrun bit", v, 32'h1000_0000);
        bwr(4'd0, 32'hFFFF_FFFF);
        bwr(4'd5, 32'(4 * DEPTH));
        collect();
        check("R4 word dropped", 32'(got_n), DEPTH);
        check("R4 final word", got_d[DEPTH - 1], 32'(16 + DEPTH - 1));
        bwr(4'd0, 32'hFFFF_FFFF);

        // receive sweep: R7
        for (int len = 1; len <= 4 * DEPTH; len++) begin
            w = (len + 3) / 4;
            rx_send(len, len);
            @(negedge clk);
            brd(4'd0, v); check("R7 receive complete", v, 32'h0400_0000);
            brd(4'd7, v); check("R7 occupancy", v, 32'(w));
            brd(4'd9, v); check("R7 length", v, 32'(len));
            for (int i = 0; i < w; i++) begin
                brd(4'd8, v); check("R7 rx word", v, 32'(len * 256 + i));
            end
            brd(4'd7, v); check("R7 drained", v, 0);
            bwr(4'd0, 32'hFFFF_FFFF);
        end

        // R8 error reads
        brd(4'd8, v); check("R8 empty data read", v, 0);
        brd(4'd0, v); check("R8 underrun read bit", v, 32'h8000_0000);
        bwr(4'd0, 32'hFFFF_FFFF);
        brd(4'd9, v); check("R8 empty length read", v, 0);
        brd(4'd0, v); check("R8 length underrun bit", v, 32'h2000_0000);
        bwr(4'd0, 32'hFFFF_FFFF);
        rx_send(8, 7);
        bwr(4'd0, 32'hFFFF_FFFF);
        brd(4'd8, v); check("R8 read past packet", v, 0);
        brd(4'd0, v); check("R8 overrun read bit", v, 32'h4000_0000);
        brd(4'd7, v); check("R8 nothing removed", v, 2);
        brd(4'd9, v); check("R8 length after", v, 8);
        brd(4'd8, v); check("R8 data after", v, 32'(7 * 256));
        brd(4'd8, v); check("R8 data after 2", v, 32'(7 * 256 + 1));
        bwr(4'd0, 32'hFFFF_FFFF);

        // R11 backpressure then R9 receive reset
        rx_send(4 * DEPTH, 3);
        @(negedge clk);
        check("R11 ready low when full", 32'(rx_ready), 0);
        bwr(4'd6, 32'hA5);
        @(negedge clk);
        brd(4'd7, v); check("R9 rx flushed", v, 0);
        check("R9 ready back", 32'(rx_ready), 1);
        brd(4'd0, v); check("R9 rx reset done", v, 32'h0480_0000);
        bwr(4'd0, 32'hFFFF_FFFF);

        // R9 link reset
        bwr(4'd4, 32'h9); bwr(4'd4, 32'hA);
        rx_send(8, 5);
        bwr(4'd0, 32'hFFFF_FFFF);
        bwr(4'd10, 32'hA5);
        @(negedge clk);
        brd(4'd3, v); check("R9 link tx flushed", v, DEPTH);
        brd(4'd7, v); check("R9 link rx flushed", v, 0);
        brd(4'd0, v); check("R9 link done bits", v, 32'h0180_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule